// File: doc/BRIEF.md
# Predicate-Register Byte Transfer Unit

This block holds a file of seven single-bit predicate flags and moves them to and from one byte lane of a 32-bit general register value. A load request copies chosen bits of the addressed byte of a source word into the predicates. Each predicate has its own bit in an 8-bit immediate mask, and only predicates whose mask bit is set are updated. A pack request gathers the predicates into a byte and masks it with the immediate. The masked byte is merged into the addressed lane of the source word, and the merged word is returned with a one-cycle write strobe.

The surrounding pipeline supplies one request per cycle: a valid strobe, an operation select, a mode select, the mask, a 2-bit lane number and the source operand. It owns the general register file, so this unit only returns the merged word. A request made in the condition-code mode is refused. The unit raises an unsupported flag for it and changes no state.

Top module: `pred_lane_xfer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all seven predicates to 0 and drives `resWe` and `unsupported` low.
- R2: The lane number `reqLane` selects bit offset 8*`reqLane`: lanes 0, 1, 2 and 3 address bits 7:0, 15:8, 23:16 and 31:24.
- R3: A valid load request (`reqOp`=0, `reqMode`=0) sets predicate i to `srcWord[8*reqLane+i]` for every i in 0..6 with `reqMask[i]`=1. All of these updates appear together on `predState` after the next rising edge.
- R4: During a load, a predicate whose mask bit is 0 keeps its value. Mask bit 7 has no effect on any predicate.
- R5: A valid pack request (`reqOp`=1, `reqMode`=0) forms a byte whose bit i (i in 0..6) is predicate i AND `reqMask[i]`. Bit 7 of this byte is always 0.
- R6: For a pack, `resWord` after the next edge holds the source word with only the addressed lane replaced by the packed byte. `resWe` is high for exactly that one cycle per pack request.
- R7: A valid request with `reqMode`=1 (condition-code mode) raises `unsupported` for one cycle after the edge. It leaves `predState` unchanged and keeps `resWe` low.
- R8: While `reqValid` is low, the predicates do not change and `resWe` and `unsupported` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 1 | 0 = load predicates from register, 1 = pack predicates into register |
| reqMode | input | 1 | 0 = predicate mode, 1 = condition-code mode (unsupported) |
| reqMask | input | 8 | Per-bit immediate mask |
| reqLane | input | 2 | Byte lane number |
| srcWord | input | 32 | Source register operand |
| resWord | output | 32 | Merged result word of the last pack |
| resWe | output | 1 | One-cycle write enable for `resWord` |
| unsupported | output | 1 | One-cycle flag for a refused condition-code request |
| predState | output | 7 | Current predicate values, bit i = predicate i |

## Verification
The bench uses all four lanes. This catches a wrong lane offset, which would read or overwrite the neighbouring byte and leave the wrong bytes untouched. It sets mask bit 7 with a full source lane and full predicates. A design that mapped bit 7 to a predicate, or packed a stray 1 into the top bit, would fail on the top bit of the lane. Load requests with sparse masks show whether unmasked predicates were cleared. Condition-code requests show any state change or spurious write. An idle cycle after each pack catches a write enable that stays high.

// File: rtl/pred_xfer_pkg.sv
package pred_xfer_pkg;

  // Operation select values on reqOp
  localparam logic OP_LOAD = 1'b0;
  localparam logic OP_PACK = 1'b1;

  // Mode select values on reqMode
  localparam logic MODE_PRED = 1'b0;
  localparam logic MODE_CC   = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic packEn;
    logic unsupEn;
  } xferStrobe_t;

endpackage

// File: rtl/pred_xfer_ctrl.sv
module pred_xfer_ctrl
  import pred_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqOp,
  input  logic        reqMode,
  output xferStrobe_t stb
);

  logic live;
  logic modeOk;

  assign live   = reqValid && !rst;
  assign modeOk = (reqMode == MODE_PRED);

  always_comb begin
    stb         = '0;
    stb.unsupEn = live && !modeOk;
    stb.loadEn  = live && modeOk && (reqOp == OP_LOAD);
    stb.packEn  = live && modeOk && (reqOp == OP_PACK);
  end

  // R7: a refused request never also starts a transfer
  assert_cc_blocks_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == MODE_CC) |-> !(stb.loadEn || stb.packEn));

  // R8: no strobe without a request
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> (stb == '0));

endmodule

// File: rtl/pred_xfer_dp.sv
module pred_xfer_dp
  import pred_xfer_pkg::*;
#(
  parameter int NUM_PRED = 7,
  parameter int WORD_W   = 32,
  parameter int LANE_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  xferStrobe_t                 stb,
  input  logic [LANE_W-1:0]           reqMask,
  input  logic [$clog2(WORD_W/LANE_W)-1:0] reqLane,
  input  logic [WORD_W-1:0]           srcWord,
  output logic [WORD_W-1:0]           resWord,
  output logic                        resWe,
  output logic                        unsupported,
  output logic [NUM_PRED-1:0]         predState
);

  localparam int LANE_CNT = WORD_W / LANE_W;
  localparam int SEL_W    = $clog2(LANE_CNT);

  logic [NUM_PRED-1:0] predQ;
  logic [NUM_PRED-1:0] predNext;
  logic [LANE_W-1:0]   laneBits;
  logic [LANE_W-1:0]   packByte;
  logic [WORD_W-1:0]   mergedWord;
  logic [LANE_W-1:0]   laneVec [LANE_CNT];

  // Split the source into lanes and pick the addressed one (R2)
  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    assign laneVec[l] = srcWord[l*LANE_W +: LANE_W];
    assign mergedWord[l*LANE_W +: LANE_W] =
      (reqLane == SEL_W'(l)) ? packByte : laneVec[l];
  end
  assign laneBits = laneVec[reqLane];

  // Per-predicate load with mask gating (R3, R4)
  for (genvar p = 0; p < NUM_PRED; p++) begin : g_pred
    assign predNext[p] = (stb.loadEn && reqMask[p]) ? laneBits[p] : predQ[p];
  end

  // Pack: predicates in low bits, unmapped positions forced to 0 (R5)
  for (genvar b = 0; b < LANE_W; b++) begin : g_pack
    if (b < NUM_PRED) begin : g_map
      assign packByte[b] = predQ[b] & reqMask[b];
    end else begin : g_zero
      assign packByte[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      predQ       <= '0;
      resWord     <= '0;
      resWe       <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      predQ       <= predNext;
      resWe       <= stb.packEn;
      unsupported <= stb.unsupEn;
      if (stb.packEn) resWord <= mergedWord;
    end
  end

  assign predState = predQ;

  // R4: predicates with a clear mask bit hold through a load
  assert_keep_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    $past(stb.loadEn) |->
      (((predQ ^ $past(predQ)) & ~$past(reqMask[NUM_PRED-1:0])) == '0));

  // R7: a refused request leaves the predicates alone
  assert_unsup_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.unsupEn && !$past(rst)) |=> ($stable(predQ) && !resWe));

  // R8: no request, no predicate change
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!stb.loadEn && !$past(rst)) |=> $stable(predQ));

endmodule

// File: rtl/pred_lane_xfer.sv
module pred_lane_xfer
  import pred_xfer_pkg::*;
#(
  parameter int NUM_PRED = 7,
  parameter int WORD_W   = 32,
  parameter int LANE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqOp,
  input  logic                reqMode,
  input  logic [LANE_W-1:0]   reqMask,
  input  logic [1:0]          reqLane,
  input  logic [WORD_W-1:0]   srcWord,
  output logic [WORD_W-1:0]   resWord,
  output logic                resWe,
  output logic                unsupported,
  output logic [NUM_PRED-1:0] predState
);

  localparam int OFF_W = $clog2(WORD_W);

  xferStrobe_t stb;

  pred_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqMode  (reqMode),
    .stb      (stb)
  );

  pred_xfer_dp #(
    .NUM_PRED (NUM_PRED),
    .WORD_W   (WORD_W),
    .LANE_W   (LANE_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .reqMask     (reqMask),
    .reqLane     (reqLane),
    .srcWord     (srcWord),
    .resWord     (resWord),
    .resWe       (resWe),
    .unsupported (unsupported),
    .predState   (predState)
  );

  logic [OFF_W-1:0]  laneOff;
  logic [WORD_W-1:0] laneMask;
  assign laneOff  = OFF_W'(reqLane) * OFF_W'(LANE_W);
  assign laneMask = {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << laneOff;

  // R6: bytes outside the addressed lane pass through unchanged
  assert_merge_keep_R6: assert property (@(posedge clk) disable iff (rst)
    resWe |-> ((resWord & ~$past(laneMask)) == ($past(srcWord) & ~$past(laneMask))));

  // R5: top bit of the packed lane is always 0
  assert_pack_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
    resWe |-> !resWord[$past(laneOff) + OFF_W'(LANE_W-1)]);

  // R7: a refused request never writes
  assert_unsup_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> !resWe);

endmodule

// File: tb/pred_lane_xfer_test.sv
module pred_lane_xfer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic        reqOp;
  logic        reqMode;
  logic [7:0]  reqMask;
  logic [1:0]  reqLane;
  logic [31:0] srcWord;
  logic [31:0] resWord;
  logic        resWe;
  logic        unsupported;
  logic [6:0]  predState;

  int   nChecks = 0;
  int   nFails  = 0;
  logic [6:0] model = '0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_lane_xfer uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqMode(reqMode),
    .reqMask(reqMask), .reqLane(reqLane), .srcWord(srcWord),
    .resWord(resWord), .resWe(resWe), .unsupported(unsupported), .predState(predState)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expPack(input logic [6:0] p, input logic [7:0] m,
                                          input logic [1:0] lane, input logic [31:0] s);
    logic [7:0]  b;
    logic [31:0] w;
    b = {1'b0, p & m[6:0]};
    w = s;
    w[lane*8 +: 8] = b;
    return w;
  endfunction

  // Apply one request for one cycle and check the registered outputs after the edge
  task automatic apply(input bit v, input bit op, input bit mode, input logic [7:0] m,
                       input logic [1:0] lane, input logic [31:0] s, input string tag);
    bit expWe, expUn;
    logic [31:0] expWord;
    @(negedge clk);
    reqValid = v; reqOp = op; reqMode = mode; reqMask = m; reqLane = lane; srcWord = s;
    expWe = 0; expUn = 0; expWord = '0;
    if (v && mode) expUn = 1;
    else if (v && op) begin expWe = 1; expWord = expPack(model, m, lane, s); end
    else if (v) begin
      for (int i = 0; i < 7; i++) if (m[i]) model[i] = s[lane*8 + i];
    end
    @(posedge clk); #1;
    reqValid = 0;
    chk({tag, " predState"}, 32'(predState), 32'(model));
    chk({tag, " resWe"}, 32'(resWe), 32'(expWe));
    chk({tag, " unsupported"}, 32'(unsupported), 32'(expUn));
    if (expWe) chk({tag, " resWord"}, resWord, expWord);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1; reqValid = 0; reqOp = 0; reqMode = 0; reqMask = 0; reqLane = 0; srcWord = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset preds", 32'(predState), 32'h0);
    chk("R1 reset we", 32'(resWe), 32'h0);
    chk("R1 reset unsup", 32'(unsupported), 32'h0);
    @(negedge clk); rst = 0;

    // R2/R3: full-mask loads on each lane, distinct patterns per lane
    apply(1, 0, 0, 8'hFF, 2'd0, 32'h0000_0055, "R3 lane0");
    apply(1, 0, 0, 8'hFF, 2'd1, 32'h0000_2A00, "R2 lane1");
    apply(1, 0, 0, 8'hFF, 2'd2, 32'h0033_0000, "R2 lane2");
    apply(1, 0, 0, 8'hFF, 2'd3, 32'h7F00_0000, "R2 lane3");
    // R4: zero mask and top-bit-only mask change nothing
    apply(1, 0, 0, 8'h00, 2'd3, 32'h0000_0000, "R4 mask0");
    apply(1, 0, 0, 8'h80, 2'd0, 32'h0000_0000, "R4 mask bit7");
    apply(1, 0, 0, 8'h05, 2'd1, 32'h0000_0000, "R4 sparse");
    // R5: all-ones predicates, full mask, full source: top bit must be 0
    apply(1, 0, 0, 8'hFF, 2'd0, 32'hFFFF_FFFF, "R3 set all");
    apply(1, 1, 0, 8'hFF, 2'd3, 32'hFFFF_FFFF, "R5 pack top");
    apply(0, 0, 0, 8'h00, 2'd0, 32'h0, "R6 we pulse");
    apply(1, 1, 0, 8'h00, 2'd0, 32'hFFFF_FFFF, "R6 mask0 merge");
    apply(1, 1, 0, 8'h5A, 2'd2, 32'h1234_5678, "R6 merge lane2");
    // R7: condition-code mode refused for both operations
    apply(1, 0, 1, 8'hFF, 2'd0, 32'h0000_0000, "R7 cc load");
    apply(1, 1, 1, 8'hFF, 2'd1, 32'hDEAD_BEEF, "R7 cc pack");
    // R8: idle cycles with active-looking inputs
    apply(0, 0, 0, 8'hFF, 2'd0, 32'h0000_0000, "R8 idle");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[0] | r[1], r[2], (r[5:3] == 3'd0), r[15:8], r[17:16], $urandom, "R3 R5 R6 random");
    end

    // R1: reset in the middle of operation
    apply(1, 0, 0, 8'hFF, 2'd0, 32'h0000_007F, "R3 preload");
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    model = '0;
    chk("R1 mid reset preds", 32'(predState), 32'h0);
    @(negedge clk); rst = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule